// File: doc/BRIEF.md
# Bus Master Address-Retry Controller

This block sequences one master's transactions on a shared processor bus whose address and data phases are separate, and on which snooping agents can force a transaction to be replayed. When the requester has work pending, the block raises a bus request and waits for grant. It then issues a one-cycle transfer-start strobe and follows the address acknowledge and the retry line. Depending on what it sees, it either lets the data phase run to completion or cancels the transaction and competes for the bus again.

During the data phase it counts data-acknowledge beats. A single transfer has one beat and a burst has `BURST_BEATS` beats. Each received beat is released to the requester through a forward strobe one cycle after its acknowledge, which leaves room for a late cancel to discard the first beat. After a cancel, the request is withdrawn for one cycle so that the snooping agent that retried can claim the bus first. The requester may present a different operation on the next attempt.

The bus clock ratio is a static input that moves the point at which retry begins to be sampled.

Top module: `bus_retry_master`

## Requirements
- R1: After reset, bus_req, xfer_start, beat_valid, xfer_done, xfer_retried and proto_err are all 0.
- R2: With xfer_pending high in idle, bus_req rises on the next cycle and stays high, for any number of cycles, until bus_gnt is sampled high.
- R3: xfer_start is high for exactly one cycle, the cycle after grant is sampled. Call this cycle age 0 of the address phase.
- R4: With ratio_slow=0, retry_in during address-phase ages 0 and 1 has no effect.
- R5: With ratio_slow=0, retry_in from address-phase age 2 onward cancels the transaction: xfer_retried pulses in that cycle and no beat_valid or xfer_done follows.
- R6: retry_in in the cycle after addr_ack cancels the transaction, even when data_ack arrives in that same cycle. addr_ack is a one-cycle pulse.
- R7: retry_in in the cycle after the first data_ack cancels the transaction, and the first beat is discarded: beat_valid stays 0.
- R8: Each accepted data_ack gives one beat_valid pulse in the following cycle. A single transfer (xfer_burst=0) takes 1 beat and a burst (xfer_burst=1) takes 4 beats. xfer_done pulses together with the last beat_valid.
- R9: After a cancel, bus_req is 0 in the next cycle whatever bus_gnt does. It rises again in the cycle after that if xfer_pending is high.
- R10: retry_in in the data phase after the retry window (from the second cycle after the first data_ack) does not cancel the transaction. It sets proto_err, which stays 1 until reset.
- R11: With ratio_slow=1, retry_in at address-phase age 2 has no effect and retry_in from age 3 onward cancels the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| xfer_pending | input | 1 | Requester has an operation to issue |
| xfer_burst | input | 1 | Operation is a burst (1) or a single beat (0); sampled at grant |
| ratio_slow | input | 1 | Static: 1:1 or 1.5:1 core-to-bus ratio selected |
| bus_gnt | input | 1 | Arbiter grant |
| addr_ack | input | 1 | Address acknowledge, one-cycle pulse |
| retry_in | input | 1 | Snoop retry from any agent |
| data_ack | input | 1 | Data beat acknowledge |
| bus_req | output | 1 | Bus request |
| xfer_start | output | 1 | Transfer-start strobe |
| beat_valid | output | 1 | Previous cycle's beat may be forwarded |
| xfer_done | output | 1 | Transaction committed |
| xfer_retried | output | 1 | Transaction cancelled this cycle |
| proto_err | output | 1 | Sticky: retry arrived too late |

## Verification
bus_req and xfer_start are registered. They are due one cycle after the stimulus, and the bench samples them at the falling edge of that cycle. xfer_retried is combinational from retry_in and is due in the same cycle retry is driven. Each beat_valid is due one cycle after its data_ack, and xfer_done coincides with the last beat_valid. proto_err is due one cycle after the late retry. The driver stamps every expected pulse with the cycle in which it must appear. At each falling edge the monitor pops the stamps and compares both the event kind and the cycle, so an early, late, missing or extra pulse is reported.

// File: rtl/brm_pkg.sv
package brm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQ     = 3'd1,
    ST_ADDR    = 3'd2,
    ST_DATA    = 3'd3,
    ST_BACKOFF = 3'd4
  } brm_state_e;
endpackage

// File: rtl/brm_age_window.sv
// Counts cycles since the transfer-start strobe and opens the retry
// sampling window once the ratio-dependent age is reached.
module brm_age_window #(
  parameter int FAST_OPEN = 2,
  parameter int SLOW_OPEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  input  logic slow_sel,
  output logic open
);
  localparam int AGE_W = $clog2(SLOW_OPEN + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(SLOW_OPEN);
  localparam logic [AGE_W-1:0] FAST_L  = AGE_W'(FAST_OPEN);

  logic [AGE_W-1:0] age_q, age_d;

  always_comb begin
    age_d = age_q;
    if (load)
      age_d = '0;
    else if (run && (age_q != AGE_MAX))
      age_d = age_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else        age_q <= age_d;
  end

  assign open = slow_sel ? (age_q >= AGE_MAX) : (age_q >= FAST_L);

  // R4
  win_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !open);
endmodule

// File: rtl/brm_beat_ctr.sv
// Counts accepted data beats, delays each by one cycle for forwarding,
// and reports whether the data-phase retry window is still open.
module brm_beat_ctr #(
  parameter int BURST_BEATS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic take,
  input  logic burst,
  output logic win,
  output logic fin,
  output logic pend
);
  localparam int CNT_W = $clog2(BURST_BEATS + 1);
  localparam logic [CNT_W-1:0] LAST_BURST = CNT_W'(BURST_BEATS - 1);
  localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             prev_q, prev_d;
  logic             fin_q, fin_d;
  logic             pend_q, pend_d;
  logic [CNT_W-1:0] last_idx;

  assign last_idx = burst ? LAST_BURST : '0;

  always_comb begin
    cnt_d  = cnt_q;
    prev_d = take;
    pend_d = take;
    fin_d  = fin_q | (take && (cnt_q == last_idx));
    if (take) cnt_d = cnt_q + 1'b1;
    if (clr) begin
      cnt_d  = '0;
      prev_d = 1'b0;
      pend_d = 1'b0;
      fin_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
      fin_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      prev_q <= prev_d;
      fin_q  <= fin_d;
      pend_q <= pend_d;
    end
  end

  assign win  = (cnt_q == '0) || ((cnt_q == ONE) && prev_q);
  assign fin  = fin_q;
  assign pend = pend_q;

  // R8
  beat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(BURST_BEATS));
  // R8
  no_take_after_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> !take);
endmodule

// File: rtl/bus_retry_master.sv
module bus_retry_master
  import brm_pkg::*;
#(
  parameter int BURST_BEATS = 4,
  parameter int FAST_OPEN   = 2,
  parameter int SLOW_OPEN   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_pending,
  input  logic xfer_burst,
  input  logic ratio_slow,
  input  logic bus_gnt,
  input  logic addr_ack,
  input  logic retry_in,
  input  logic data_ack,
  output logic bus_req,
  output logic xfer_start,
  output logic beat_valid,
  output logic xfer_done,
  output logic xfer_retried,
  output logic proto_err
);
  brm_state_e state_q, state_d;
  logic ts_q, burst_q, err_q;
  logic granted, addr_win, data_win, fin, pend;
  logic abort_early, abort_data, late_retry, take;

  assign granted     = (state_q == ST_REQ) && bus_gnt;
  assign abort_early = (state_q == ST_ADDR) && retry_in && addr_win;
  assign abort_data  = (state_q == ST_DATA) && retry_in && data_win;
  assign late_retry  = (state_q == ST_DATA) && retry_in && !data_win;
  assign take        = (state_q == ST_DATA) && !fin && data_ack && !abort_data;

  brm_age_window #(.FAST_OPEN(FAST_OPEN), .SLOW_OPEN(SLOW_OPEN)) u_age (
    .clk(clk), .rst_n(rst_n), .load(granted), .run(state_q == ST_ADDR),
    .slow_sel(ratio_slow), .open(addr_win)
  );

  brm_beat_ctr #(.BURST_BEATS(BURST_BEATS)) u_beats (
    .clk(clk), .rst_n(rst_n), .clr(state_q != ST_DATA), .take(take),
    .burst(burst_q), .win(data_win), .fin(fin), .pend(pend)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (xfer_pending) state_d = ST_REQ;
      ST_REQ:     if (bus_gnt) state_d = ST_ADDR;
      ST_ADDR: begin
        if (abort_early)   state_d = ST_BACKOFF;
        else if (addr_ack) state_d = ST_DATA;
      end
      ST_DATA: begin
        if (abort_data) state_d = ST_BACKOFF;
        else if (fin)   state_d = ST_IDLE;
      end
      ST_BACKOFF: state_d = xfer_pending ? ST_REQ : ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ts_q    <= 1'b0;
      burst_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ts_q    <= granted;
      if (granted)    burst_q <= xfer_burst;
      if (late_retry) err_q   <= 1'b1;
    end
  end

  assign bus_req      = (state_q == ST_REQ);
  assign xfer_start   = ts_q;
  assign beat_valid   = pend && !abort_data;
  assign xfer_done    = (state_q == ST_DATA) && fin && !abort_data;
  assign xfer_retried = abort_early || abort_data;
  assign proto_err    = err_q;

  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);
  // R9
  backoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_retried |=> !bus_req);
  // R10
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
  // R5
  done_vs_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_done && xfer_retried));
  // R6
  aack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ack |=> !addr_ack);
endmodule

// File: tb/sim_bus_retry_master.sv
module sim_bus_retry_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_pending = 0, xfer_burst = 0, ratio_slow = 0, bus_gnt = 0;
  logic addr_ack = 0, retry_in = 0, data_ack = 0;
  logic bus_req, xfer_start, beat_valid, xfer_done, xfer_retried, proto_err;

  always #4 clk = ~clk;

  bus_retry_master u0 (
    .clk(clk), .rst_n(rst_n), .xfer_pending(xfer_pending), .xfer_burst(xfer_burst),
    .ratio_slow(ratio_slow), .bus_gnt(bus_gnt), .addr_ack(addr_ack),
    .retry_in(retry_in), .data_ack(data_ack), .bus_req(bus_req),
    .xfer_start(xfer_start), .beat_valid(beat_valid), .xfer_done(xfer_done),
    .xfer_retried(xfer_retried), .proto_err(proto_err)
  );

  localparam int EV_BEAT = 1, EV_DONE = 2, EV_RETRY = 3;
  typedef struct { int code; int at; } ev_t;
  ev_t expq[$];
  int cyc = 0;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic push(input int code);
    ev_t e;
    e.code = code; e.at = cyc;
    expq.push_back(e);
  endtask

  task automatic pop(input int code);
    ev_t e;
    if (expq.size() == 0) begin
      chk(1'b0, "R5/R7/R8 unexpected event", code, 0);
    end else begin
      e = expq.pop_front();
      chk(e.code == code, "R8 scoreboard event kind", code, e.code);
      chk(e.at == cyc, "R8 scoreboard event cycle", cyc, e.at);
    end
  endtask

  // monitor
  always @(negedge clk) if (rst_n && !finished) begin
    if (beat_valid)   pop(EV_BEAT);
    if (xfer_done)    pop(EV_DONE);
    if (xfer_retried) pop(EV_RETRY);
  end

  task automatic summary();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // From idle: request, one wait cycle, grant, start. Ends in age-1 cycle.
  task automatic get_bus();
    step(); xfer_pending = 1;
    @(negedge clk); chk(bus_req == 0, "R2 idle", bus_req, 0);
    step();
    @(negedge clk); chk(bus_req == 1, "R2 request", bus_req, 1);
    step(); bus_gnt = 1;
    @(negedge clk); chk(bus_req == 1, "R2 held until grant", bus_req, 1);
    step(); bus_gnt = 0; xfer_pending = 0;
    @(negedge clk); chk(xfer_start == 1, "R3 start", xfer_start, 1);
    step();
    @(negedge clk); chk(xfer_start == 0, "R3 start one cycle", xfer_start, 0);
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({bus_req, xfer_start, beat_valid, xfer_done, xfer_retried, proto_err} == 6'b0,
        "R1 reset outputs", {bus_req, xfer_start, beat_valid, xfer_done, xfer_retried, proto_err}, 0);

    // A: single beat, retry before window ignored (R4, R8)
    xfer_burst = 0; ratio_slow = 0;
    get_bus();
    retry_in = 1;                        // age 1: R4 ignored
    step(); retry_in = 0; addr_ack = 1;  // age 2
    step(); addr_ack = 0; data_ack = 1;  // qualified cycle, beat 1
    step(); data_ack = 0; push(EV_BEAT); push(EV_DONE);
    step();
    @(negedge clk); chk(bus_req == 0, "R8 idle after done", bus_req, 0);

    // C: early retry in window (R5), back-off (R9), replay
    get_bus();
    step(); retry_in = 1; push(EV_RETRY); // age 2
    step(); retry_in = 0; xfer_pending = 1; bus_gnt = 1;
    @(negedge clk); chk(bus_req == 0, "R9 back-off drops request", bus_req, 1'b0);
    step();
    @(negedge clk); chk(bus_req == 1, "R9 re-request", bus_req, 1);
    chk(xfer_start == 0, "R9 grant ignored in back-off", xfer_start, 0);
    step(); bus_gnt = 0; xfer_pending = 0;
    @(negedge clk); chk(xfer_start == 1, "R3 restart", xfer_start, 1);
    step(); step(); addr_ack = 1;
    step(); addr_ack = 0; data_ack = 1;
    step(); data_ack = 0; push(EV_BEAT); push(EV_DONE);
    step();

    // D: qualified retry with data_ack in same cycle (R6)
    get_bus();
    step(); addr_ack = 1;
    step(); addr_ack = 0; retry_in = 1; data_ack = 1; push(EV_RETRY);
    step(); retry_in = 0; data_ack = 0;
    @(negedge clk); chk(bus_req == 0, "R6 cancelled, back-off", bus_req, 0);
    step();
    @(negedge clk); chk(bus_req == 0, "R6 idle, no pending", bus_req, 0);

    // E: burst, retry after first data_ack discards beat (R7)
    xfer_burst = 1;
    get_bus();
    step(); addr_ack = 1;
    step(); addr_ack = 0; data_ack = 1;
    step(); retry_in = 1; push(EV_RETRY);
    @(negedge clk); chk(beat_valid == 0, "R7 first beat discarded", beat_valid, 0);
    step(); retry_in = 0; data_ack = 0;
    step();
    @(negedge clk); chk(proto_err == 0, "R7 no error for in-window retry", proto_err, 0);

    // B: burst of 4 with late retry (R8, R10)
    get_bus();
    step(); addr_ack = 1;
    step(); addr_ack = 0; data_ack = 1;
    step(); push(EV_BEAT);
    step(); retry_in = 1; push(EV_BEAT);
    step(); retry_in = 0; push(EV_BEAT);
    @(negedge clk); chk(proto_err == 1, "R10 late retry flagged", proto_err, 1);
    step(); data_ack = 0; push(EV_BEAT); push(EV_DONE);
    step();

    // F: slow ratio window (R11)
    xfer_burst = 0; ratio_slow = 1;
    get_bus();
    step(); retry_in = 1;                // age 2: ignored
    step(); push(EV_RETRY);              // age 3: honoured
    step(); retry_in = 0;
    @(negedge clk); chk(bus_req == 0, "R11 back-off after slow retry", bus_req, 0);
    chk(proto_err == 1, "R10 error sticky", proto_err, 1);
    step(); step();

    chk(expq.size() == 0, "R8 all expected events seen", expq.size(), 0);
    summary();
  end
endmodule